// File: doc/BRIEF.md
# Dithered Phase Accumulator

This block is the phase front end of a numerically controlled oscillator. Each cycle that `in_valid` is high, it adds the phase increment to a phase register. The register wraps around at its full width, and after reset it holds a parameterised start phase. The phase word is split into three fields. Counting from the top, these are two quadrant bits, `ADDR_W` address bits and `FRAC_W` fractional bits. The increment port has the same width as the phase word, so the increment sets the output frequency directly.

Before the fractional bits are dropped, the block can add a pseudo-random offset that spans the whole fractional field, from zero up to just under one address step. A maximal-length shift-register sequence generates this offset and steps once per valid input, whatever the phase value. The carry from the offset sometimes lifts the address by one step and sometimes does not, so the address rounds up with a probability equal to the fractional phase. This breaks the periodic truncation error that would otherwise create spurs in the spectrum.

The block registers the integer lookup phase (quadrant plus address) and the remaining fractional error for a downstream sine table. They appear one cycle after the valid input, together with `out_valid`. With `FRAC_W = 0` the block runs in integer mode: the phase is always an exact address and no offset is added.

Top module: `phase_dither_acc`

## Requirements
- R1: The phase register is `ADDR_W+2+FRAC_W` bits wide. It adds `in_incr` on every cycle with `in_valid` high, wrapping modulo 2^(ADDR_W+2+FRAC_W), and holds its value on cycles with `in_valid` low.
- R2: While reset is held and before the first valid input, `out_valid`, `out_phase` and `out_err` are 0. The phase register restarts at `INIT_PHASE`, so the first valid input reports `INIT_PHASE`.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock.
- R4: With dithering off (`DITHER_EN = 0`), the output produced by a valid input is the phase register value before that input's increment. `out_phase` is its top `ADDR_W+2` bits and `out_err` is its low `FRAC_W` bits.
- R5: In integer mode (`FRAC_W = 0`), the k-th valid output (k counted from 0) is exactly `INIT_PHASE + k*increment` modulo 2^(ADDR_W+2), and `out_err` is 0.
- R6: With dithering on, the concatenation {`out_phase`,`out_err`} minus the pre-increment phase, taken modulo 2^(ADDR_W+2+FRAC_W), lies in [0, 2^FRAC_W-1]. Any carry out of the top bit is discarded, so a round-up from the highest address wraps `out_phase` to 0.
- R7: The offset is the low `FRAC_W` bits of a maximal-length shift register of `max(LFSR_W,FRAC_W)` bits, with period 2^L-1, that advances only on valid inputs. For a fixed phase whose fractional part is f, any 2^L-1 consecutive valid outputs raise the address exactly f*2^(L-FRAC_W) times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Increment is valid this cycle |
| in_incr | input | ADDR_W+2+FRAC_W | Phase increment |
| out_valid | output | 1 | Output phase is valid |
| out_phase | output | ADDR_W+2 | Integer lookup phase: quadrant bits above address bits |
| out_err | output | max(FRAC_W,1) | Fractional bits dropped from the dithered phase |

## Verification
Random increments with random idle gaps run through three instances that share the stimulus: one dithered, one undithered, and one in integer mode. The undithered and integer-mode instances are compared exactly with a running phase model, which separates correct accumulation and wrap from errors in the hold-on-idle path. The dithered instance is checked against the bound of R6 on every output. For the offset itself, the phase is frozen at fractional values 0, 13 and 31, and the round-ups are counted over one full sequence period with idle cycles inserted. The last of these values sits at the top address, so it also tests the wrap. The count shows whether the offset is uniform and whether the sequence steps only on valid inputs.

// File: rtl/phase_dither_pkg.sv
package phase_dither_pkg;

    // Feedback masks for maximal-length Fibonacci shift registers, bit n-1 = tap n.
    function automatic logic [23:0] lfsr_taps(input int unsigned w);
        case (w)
            2:       return 24'h000003;
            3:       return 24'h000006;
            4:       return 24'h00000C;
            5:       return 24'h000014;
            6:       return 24'h000030;
            7:       return 24'h000060;
            8:       return 24'h0000B8;
            9:       return 24'h000110;
            10:      return 24'h000240;
            11:      return 24'h000500;
            12:      return 24'h000829;
            13:      return 24'h00100D;
            14:      return 24'h002015;
            15:      return 24'h006000;
            16:      return 24'h00D008;
            17:      return 24'h012000;
            18:      return 24'h020400;
            19:      return 24'h040023;
            20:      return 24'h090000;
            21:      return 24'h140000;
            22:      return 24'h300000;
            23:      return 24'h420000;
            24:      return 24'hE10000;
            default: return 24'h000000;
        endcase
    endfunction

endpackage

// File: rtl/pd_lfsr.sv
module pd_lfsr #(
    parameter int unsigned W     = 8,
    parameter int unsigned OUT_W = 5,
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] dither
);
    localparam logic [23:0]  TAPS_ALL = phase_dither_pkg::lfsr_taps(W);
    localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];

    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_t;

    lfsr_t cur_q, nxt_d;
    logic  fb;

    always_comb begin
        nxt_d = cur_q;
        fb    = ^(cur_q.st & TAPS);
        if (step) begin
            nxt_d.st = {cur_q.st[W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st <= SEED;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dither = cur_q.st[OUT_W-1:0];
endmodule

// File: rtl/pd_accum.sv
module pd_accum #(
    parameter int unsigned   PH_W = 15,
    parameter logic [PH_W-1:0] INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PH_W-1:0] in_incr,
    output logic [PH_W-1:0] acc
);
    typedef struct packed {
        logic [PH_W-1:0] acc;
    } acc_t;

    acc_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (in_valid) begin
            nxt_d.acc = cur_q.acc + in_incr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.acc <= INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign acc = cur_q.acc;
endmodule

// File: rtl/pd_trunc.sv
module pd_trunc #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned FRAC_W = 5,
    localparam int unsigned PH_W  = ADDR_W + 2 + FRAC_W,
    localparam int unsigned INT_W = ADDR_W + 2,
    localparam int unsigned ERR_W = (FRAC_W > 0) ? FRAC_W : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PH_W-1:0]  acc,
    input  logic [PH_W-1:0]  dith,
    output logic             out_valid,
    output logic [INT_W-1:0] out_phase,
    output logic [ERR_W-1:0] out_err
);
    localparam logic [PH_W-1:0] LOW_MASK = (PH_W'(1) << FRAC_W) - PH_W'(1);

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] ph;
        logic [ERR_W-1:0] err;
    } out_t;

    out_t            cur_q, nxt_d;
    logic [PH_W-1:0] sum;

    always_comb begin
        nxt_d     = cur_q;
        sum       = acc + dith;          // carry out of the top bit is dropped
        nxt_d.vld = in_valid;
        if (in_valid) begin
            nxt_d.ph  = INT_W'(sum >> FRAC_W);
            nxt_d.err = ERR_W'(sum & LOW_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_valid = cur_q.vld;
    assign out_phase = cur_q.ph;
    assign out_err   = cur_q.err;
endmodule

// File: rtl/phase_dither_acc.sv
module phase_dither_acc #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned FRAC_W    = 5,
    parameter bit          DITHER_EN = 1'b1,
    parameter int unsigned LFSR_W    = 8,
    parameter logic [ADDR_W+FRAC_W+1:0] INIT_PHASE = '0,
    localparam int unsigned PH_W  = ADDR_W + 2 + FRAC_W,
    localparam int unsigned INT_W = ADDR_W + 2,
    localparam int unsigned ERR_W = (FRAC_W > 0) ? FRAC_W : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PH_W-1:0]  in_incr,
    output logic             out_valid,
    output logic [INT_W-1:0] out_phase,
    output logic [ERR_W-1:0] out_err
);
    localparam int unsigned LW_MIN = (LFSR_W < FRAC_W) ? FRAC_W : LFSR_W;
    localparam int unsigned LW     = (LW_MIN < 2) ? 2 : LW_MIN;

    logic [PH_W-1:0] acc_w;
    logic [PH_W-1:0] dith_w;

    pd_accum #(
        .PH_W (PH_W),
        .INIT (INIT_PHASE)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_incr  (in_incr),
        .acc      (acc_w)
    );

    generate
        if (DITHER_EN && (FRAC_W > 0)) begin : g_dither
            logic [FRAC_W-1:0] frac_off;
            pd_lfsr #(
                .W     (LW),
                .OUT_W (FRAC_W)
            ) u_lfsr (
                .clk    (clk),
                .rst_n  (rst_n),
                .step   (in_valid),
                .dither (frac_off)
            );
            assign dith_w = PH_W'(frac_off);
        end else begin : g_plain
            assign dith_w = '0;
        end
    endgenerate

    pd_trunc #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W)
    ) u_trunc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .acc       (acc_w),
        .dith      (dith_w),
        .out_valid (out_valid),
        .out_phase (out_phase),
        .out_err   (out_err)
    );
endmodule

// File: rtl/phase_dither_acc_chk.sv
module phase_dither_acc_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned FRAC_W    = 5,
    parameter bit          DITHER_EN = 1'b1,
    localparam int unsigned PH_W  = ADDR_W + 2 + FRAC_W,
    localparam int unsigned INT_W = ADDR_W + 2,
    localparam int unsigned ERR_W = (FRAC_W > 0) ? FRAC_W : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PH_W-1:0]  in_incr,
    input logic             out_valid,
    input logic [INT_W-1:0] out_phase,
    input logic [ERR_W-1:0] out_err,
    input logic [PH_W-1:0]  acc
);
    localparam logic [PH_W-1:0] SPAN = PH_W'(1) << FRAC_W;

    logic [PH_W-1:0] acc_prev_q;
    logic [PH_W-1:0] full;
    logic [PH_W-1:0] diff;

    always_ff @(posedge clk) begin
        if (!rst_n) acc_prev_q <= '0;
        else        acc_prev_q <= acc;
    end

    assign full = (PH_W'(out_phase) << FRAC_W) | PH_W'(out_err);
    assign diff = full - acc_prev_q;

    // R1
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> acc == $past(acc + in_incr));

    // R1
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc));

    // R3
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    dither_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> diff < SPAN);

    generate
        if (!DITHER_EN || (FRAC_W == 0)) begin : g_exact
            // R4
            exact_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> diff == '0);
        end
    endgenerate
endmodule

bind phase_dither_acc phase_dither_acc_chk #(
    .ADDR_W    (ADDR_W),
    .FRAC_W    (FRAC_W),
    .DITHER_EN (DITHER_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_incr   (in_incr),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .out_err   (out_err),
    .acc       (acc_w)
);

// File: tb/tb_phase_dither_acc.sv
`timescale 1ns/1ps
module tb_phase_dither_acc;
    localparam int AW = 8;
    localparam int FW = 5;
    localparam int LW = 8;
    localparam int PW = AW + 2 + FW;   // 15
    localparam int IW = AW + 2;        // 10
    localparam logic [PW-1:0] INIT_F = 15'h5A37;
    localparam logic [IW-1:0] INIT_I = 10'h2C3;
    localparam int PERIOD = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic vin;
    logic [PW-1:0] incf;
    logic [IW-1:0] inci;

    logic d_v, n_v, i_v;
    logic [IW-1:0] d_ph, n_ph, i_ph;
    logic [FW-1:0] d_err, n_err;
    logic [0:0]    i_err;

    logic [PW-1:0] mf;
    logic [IW-1:0] mi;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    phase_dither_acc #(.ADDR_W(AW), .FRAC_W(FW), .DITHER_EN(1'b1), .LFSR_W(LW),
                       .INIT_PHASE(INIT_F)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_incr(incf),
        .out_valid(d_v), .out_phase(d_ph), .out_err(d_err));

    phase_dither_acc #(.ADDR_W(AW), .FRAC_W(FW), .DITHER_EN(1'b0), .LFSR_W(LW),
                       .INIT_PHASE(INIT_F)) dut_nd (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_incr(incf),
        .out_valid(n_v), .out_phase(n_ph), .out_err(n_err));

    phase_dither_acc #(.ADDR_W(AW), .FRAC_W(0), .DITHER_EN(1'b1), .LFSR_W(LW),
                       .INIT_PHASE(INIT_I)) dut_int (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_incr(inci),
        .out_valid(i_v), .out_phase(i_ph), .out_err(i_err));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Offset from the pre-increment phase, modulo the phase width.
    function automatic logic [PW-1:0] offset_of(input logic [IW-1:0] ph,
                                                input logic [FW-1:0] er,
                                                input logic [PW-1:0] pre);
        return {ph, er} - pre;
    endfunction

    task automatic apply(input logic v, input logic [PW-1:0] f, input logic [IW-1:0] i);
        vin  = v;
        incf = f;
        inci = i;
        @(negedge clk);
        // R3 valid delay on every instance
        chk((d_v == v) && (n_v == v) && (i_v == v), "R3 out_valid",
            {d_v, n_v, i_v}, {v, v, v});
        if (v) begin
            // R4 undithered truncation, R1 accumulation model
            chk({n_ph, n_err} == mf, "R4/R1 undithered phase", {n_ph, n_err}, mf);
            // R5 integer mode exact
            chk((i_ph == mi) && (i_err == 1'b0), "R5 integer phase", {i_ph, i_err}, {mi, 1'b0});
            // R6 dither bound
            chk(offset_of(d_ph, d_err, mf) < PW'(1 << FW), "R6 dither offset",
                offset_of(d_ph, d_err, mf), 31);
            mf = mf + f;
            mi = mi + i;
        end
    endtask

    task automatic window(input logic [PW-1:0] target);
        int ups;
        int expct;
        apply(1'b1, target - mf, IW'($urandom));
        ups = 0;
        for (int k = 0; k < PERIOD; k++) begin
            if ($urandom % 4 == 0) apply(1'b0, PW'($urandom), IW'($urandom));
            apply(1'b1, '0, IW'($urandom));
            if (d_ph != mf[PW-1:FW]) ups++;
        end
        expct = int'(mf[FW-1:0]) * (1 << (LW - FW));
        // R7 round-up count over one period
        chk(ups == expct, "R7 round-up count", ups, expct);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired act=hung exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst_n = 1'b0;
        vin   = 1'b0;
        incf  = '0;
        inci  = '0;
        mf    = INIT_F;
        mi    = INIT_I;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk({d_v, n_v, i_v} == 3'b000, "R2 valid in reset", {d_v, n_v, i_v}, 0);
        chk((d_ph == 0) && (n_ph == 0) && (i_ph == 0) && (d_err == 0) && (n_err == 0),
            "R2 outputs in reset", {d_ph, n_ph, i_ph}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({d_v, n_v, i_v} == 3'b000, "R2 idle after reset", {d_v, n_v, i_v}, 0);
        // R2 first valid reports the start phase
        apply(1'b1, 15'h0011, 10'h005);
        chk(mf == INIT_F + 15'h0011, "R2 start phase taken", mf, INIT_F + 15'h0011);

        // R1 wrap with the largest increment, idle holds
        apply(1'b1, '1, '1);
        apply(1'b0, 15'h1234, 10'h155);
        apply(1'b1, 15'h4000, 10'h200);

        // random mix of increments and gaps (R1 R3 R4 R5 R6)
        for (int n = 0; n < 600; n++) begin
            apply(($urandom % 4) != 0, PW'($urandom), IW'($urandom));
        end

        // R7 fixed phase windows; last one at the top address exercises the wrap of R6
        window(15'h1200);
        window(15'h238D);
        window(15'h7FFF);

        apply(1'b0, '0, '0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule